// File: doc/BRIEF.md
# Event Timer with One Comparator Channel

This block keeps a free-running 64-bit count of clock ticks and raises an interrupt when the count reaches a programmed comparator value. Software reaches it over a simple 32-bit register bus. The bus is single cycle: writes are strobed by `req_i` and `we_i`, and read data follows `addr_i` combinationally. Every 64-bit quantity is exposed as a low word and a high word at adjacent word addresses.

The comparator channel runs in one of two modes. In one-shot mode it fires once at the programmed value. In periodic mode it adds a stored period to itself on every match, so it fires at a fixed rate. A set-value flag in the channel configuration controls where the next comparator write goes: with the flag set, the write loads the comparator itself. With the flag clear in periodic mode, the write loads the period. A 32-bit mode narrows the channel to the low word. In that mode the carry out of the low counter word is dropped, the upper counter word is held at zero, and the upper comparator word plays no part in matching.

Register map (byte addresses, only word-aligned accesses decode):
- 0x00: counter low word.
- 0x04: counter high word.
- 0x08: global config, bit 0 = count enable.
- 0x0C: channel config. Bit 0 = channel enable, bit 1 = periodic, bit 2 = set-value, bit 3 = 32-bit mode, bit 4 = 64-bit capable (read-only).
- 0x10: comparator low word.
- 0x14: comparator high word.

Top module: `evt_timer`

## Requirements
- R1: After reset the counter, both config registers and the comparator read as zero, except channel-config bit 4, and `irq_o` is low.
- R2: The counter advances by one per clock only while global-config bit 0 is set. Writes to 0x00/0x04 load the counter only while that bit is clear, and are ignored while it is set.
- R3: The counter reads as a low word at 0x00 and a high word at 0x04, and each half can be loaded separately.
- R4: Channel-config bit 4 reads as 1 whatever is written to it.
- R5: With channel-config bit 3 set, 0x04 reads zero and the low counter word wraps to zero without carrying into the high word. Matching uses only the low 32 bits, so a non-zero upper comparator word does not prevent a match.
- R6: A write to 0x14 goes to a holding register and leaves the visible comparator unchanged. A following write to 0x10 commits the held high word together with the new low word.
- R7: With channel-config bits 1 and 2 set, a comparator write loads the comparator. Bit 2 clears after any write to 0x10 or 0x14. Comparator writes in periodic mode with bit 2 clear load the period and leave the comparator unchanged.
- R8: In periodic mode each match adds the period to the comparator and produces another interrupt.
- R9: With channel-config bit 1 clear, a match produces one interrupt and the comparator keeps its value.
- R10: `irq_o` is a one-cycle pulse that rises one clock after the counter equals the comparator. This happens only while both the channel enable (channel-config bit 0) and the count enable (global-config bit 0) are set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write qualifier for the access |
| addr_i | input | 5 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 1 | One-cycle interrupt pulse on a comparator match |

## Verification
A corrupted counter or comparator shows up at the interrupt pin: pulses land in the wrong clock cycle, come too often, or never come. The scoreboard therefore predicts the exact cycle of every pulse from the programmed values. A wrong set-value flag or holding register shows up when the config and comparator words are read back straight after the write that should have changed or preserved them. A carry leak in 32-bit mode appears in the high counter word within a few cycles of the low-word wrap.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned CW = 2 * DW;
  localparam int unsigned AW = 5;

  localparam logic [2:0] W_CNT_LO = 3'd0;
  localparam logic [2:0] W_CNT_HI = 3'd1;
  localparam logic [2:0] W_GCFG   = 3'd2;
  localparam logic [2:0] W_CCFG   = 3'd3;
  localparam logic [2:0] W_CMP_LO = 3'd4;
  localparam logic [2:0] W_CMP_HI = 3'd5;

  typedef struct packed {
    logic m32;
    logic setval;
    logic periodic;
    logic en;
  } ch_cfg_t;

  typedef struct packed {
    logic cnt_lo;
    logic cnt_hi;
    logic cmp_lo;
    logic cmp_hi;
  } wr_stb_t;
endpackage

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
  import evt_timer_pkg::*;
#(
  parameter bit CAP64 = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [3:0]    cfg_wdata_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] cmp_i,
  output logic          g_en_o,
  output ch_cfg_t       cfg_o,
  output wr_stb_t       stb_o,
  output logic [DW-1:0] rdata_o
);
  logic [2:0] word;
  logic       wr;
  logic       g_en_q, en_q, per_q, setval_q, m32_q, m32_eff;

  assign word = addr_i[AW-1:2];
  assign wr   = req_i && we_i && (addr_i[1:0] == 2'b00);

  assign stb_o.cnt_lo = wr && (word == W_CNT_LO);
  assign stb_o.cnt_hi = wr && (word == W_CNT_HI);
  assign stb_o.cmp_lo = wr && (word == W_CMP_LO);
  assign stb_o.cmp_hi = wr && (word == W_CMP_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      g_en_q   <= 1'b0;
      en_q     <= 1'b0;
      per_q    <= 1'b0;
      setval_q <= 1'b0;
      m32_q    <= 1'b0;
    end else begin
      if (wr && word == W_GCFG) g_en_q <= cfg_wdata_i[0];
      if (wr && word == W_CCFG) begin
        en_q     <= cfg_wdata_i[0];
        per_q    <= cfg_wdata_i[1];
        setval_q <= cfg_wdata_i[2];
        m32_q    <= cfg_wdata_i[3];
      end else if (stb_o.cmp_lo || stb_o.cmp_hi) begin
        setval_q <= 1'b0;  // either half consumes the flag
      end
    end
  end

  generate
    if (CAP64) begin : g_cap64
      assign m32_eff = m32_q;
    end else begin : g_cap32
      assign m32_eff = 1'b1;
    end
  endgenerate

  assign g_en_o        = g_en_q;
  assign cfg_o.en       = en_q;
  assign cfg_o.periodic = per_q;
  assign cfg_o.setval   = setval_q;
  assign cfg_o.m32      = m32_eff;

  always_comb begin
    rdata_o = '0;
    if (addr_i[1:0] == 2'b00) begin
      unique case (word)
        W_CNT_LO: rdata_o = cnt_i[DW-1:0];
        W_CNT_HI: rdata_o = m32_eff ? '0 : cnt_i[CW-1:DW];
        W_GCFG:   rdata_o = {{(DW-1){1'b0}}, g_en_q};
        W_CCFG:   rdata_o = {{(DW-5){1'b0}}, CAP64, m32_eff, setval_q, per_q, en_q};
        W_CMP_LO: rdata_o = cmp_i[DW-1:0];
        W_CMP_HI: rdata_o = cmp_i[CW-1:DW];
        default:  rdata_o = '0;
      endcase
    end
  end

  a_r7_setval_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_o.cmp_lo || stb_o.cmp_hi) |=> !cfg_o.setval);

  a_r4_cap_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == {W_CCFG, 2'b00}) |-> (rdata_o[4] == CAP64));
endmodule

// File: rtl/evt_timer_counter.sv
module evt_timer_counter
  import evt_timer_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          m32_i,
  input  logic          lo_we_i,
  input  logic          hi_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (en_i) begin
      // narrow mode: drop the low-word carry, park the high word at zero
      if (m32_i) cnt_q <= {{DW{1'b0}}, cnt_q[DW-1:0] + DW'(1)};
      else       cnt_q <= cnt_q + CW'(1);
    end else begin
      if (lo_we_i) cnt_q[DW-1:0]  <= wdata_i;
      if (hi_we_i) cnt_q[CW-1:DW] <= wdata_i;
    end
  end

  assign cnt_o = cnt_q;

  a_r2_frozen_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !lo_we_i && !hi_we_i) |=> $stable(cnt_q));

  a_r5_upper_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && m32_i) |=> (cnt_q[CW-1:DW] == '0));
endmodule

// File: rtl/evt_timer_cmp.sv
module evt_timer_cmp
  import evt_timer_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ch_cfg_t       cfg_i,
  input  logic          g_en_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          lo_we_i,
  input  logic          hi_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [CW-1:0] cmp_o,
  output logic          irq_o
);
  logic [DW-1:0] cmp_hold_q, per_hold_q;
  logic [CW-1:0] cmp_q, per_q;
  logic          irq_q, load_cmp, eq_lo, eq_hi, match;

  assign load_cmp = cfg_i.setval || !cfg_i.periodic;
  assign eq_lo    = cnt_i[DW-1:0] == cmp_q[DW-1:0];
  assign eq_hi    = cnt_i[CW-1:DW] == cmp_q[CW-1:DW];
  assign match    = cfg_i.en && g_en_i && eq_lo && (cfg_i.m32 || eq_hi);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_hold_q <= '0;
      per_hold_q <= '0;
    end else if (hi_we_i) begin
      if (load_cmp) cmp_hold_q <= wdata_i;
      else          per_hold_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '0;
      per_q <= '0;
    end else if (lo_we_i) begin
      // commit only on the low half so no torn value is ever compared
      if (load_cmp) cmp_q <= {cmp_hold_q, wdata_i};
      else          per_q <= {per_hold_q, wdata_i};
    end else if (match && cfg_i.periodic) begin
      if (cfg_i.m32) cmp_q[DW-1:0] <= cmp_q[DW-1:0] + per_q[DW-1:0];
      else           cmp_q         <= cmp_q + per_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= match;
  end

  assign cmp_o = cmp_q;
  assign irq_o = irq_q;

  a_r9_oneshot_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && !cfg_i.periodic && !lo_we_i) |=> $stable(cmp_q));

  a_r8_periodic_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && cfg_i.periodic && !lo_we_i && per_q[DW-1:0] != '0) |=> !$stable(cmp_q));

  a_r10_irq_on_equal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> ($past(cnt_i[DW-1:0]) == $past(cmp_q[DW-1:0]) && $past(g_en_i)));
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter bit CAP64 = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  logic          g_en;
  ch_cfg_t       ch_cfg;
  wr_stb_t       stb;
  logic [CW-1:0] cnt, cmp;

  evt_timer_regs #(.CAP64(CAP64)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .cfg_wdata_i(wdata_i[3:0]),
    .cnt_i      (cnt),
    .cmp_i      (cmp),
    .g_en_o     (g_en),
    .cfg_o      (ch_cfg),
    .stb_o      (stb),
    .rdata_o    (rdata_o)
  );

  evt_timer_counter u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (g_en),
    .m32_i  (ch_cfg.m32),
    .lo_we_i(stb.cnt_lo),
    .hi_we_i(stb.cnt_hi),
    .wdata_i(wdata_i),
    .cnt_o  (cnt)
  );

  evt_timer_cmp u_cmp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cfg_i  (ch_cfg),
    .g_en_i (g_en),
    .cnt_i  (cnt),
    .lo_we_i(stb.cmp_lo),
    .hi_we_i(stb.cmp_hi),
    .wdata_i(wdata_i),
    .cmp_o  (cmp),
    .irq_o  (irq_o)
  );

  a_r3_hi_masked_m32: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_cfg.m32 && addr_i == {W_CNT_HI, 2'b00}) |-> (rdata_o == '0));
endmodule

// File: tb/evt_timer_tb.sv
module evt_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;

  int vectors = 0, miscmp = 0, cyc = 0, last_e = 0;
  int exp_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  evt_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    last_e = cyc;
    #1 req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  // monitor: every irq pulse must match the next predicted cycle
  always @(negedge clk) begin
    if (rst_n && irq) begin
      vectors++;
      if (exp_q.size() == 0) begin
        miscmp++;
        $display("FAIL R10 unexpected irq act=cycle %0d exp=none", cyc);
      end else begin
        int x;
        x = exp_q.pop_front();
        if (x != cyc) begin
          miscmp++;
          $display("FAIL R10 irq timing act=%0d exp=%0d", cyc, x);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    miscmp++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    logic [31:0] v1, v2;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rd_chk("R1 cnt_lo", 5'h00, 32'd0);
    rd_chk("R1 cnt_hi", 5'h04, 32'd0);
    rd_chk("R1 gcfg", 5'h08, 32'd0);
    rd_chk("R1 ccfg", 5'h0C, 32'h10);
    rd_chk("R1 cmp_lo", 5'h10, 32'd0);
    rd_chk("R1 cmp_hi", 5'h14, 32'd0);

    // R4 capability bit is read-only
    wr(5'h0C, 32'hFFFF_FFE0);
    rd_chk("R4 cap stays", 5'h0C, 32'h10);

    // R2/R3 load halves while stopped, no counting
    wr(5'h00, 32'd100);
    wr(5'h04, 32'h0000_00AB);
    rd_chk("R3 hi load", 5'h04, 32'h0000_00AB);
    wr(5'h04, 32'd0);
    rd_chk("R3 lo load", 5'h00, 32'd100);
    repeat (5) @(negedge clk);
    rd_chk("R2 frozen", 5'h00, 32'd100);

    // R6 high word held until low word write
    wr(5'h14, 32'd7);
    rd_chk("R6 hi held", 5'h14, 32'd0);
    wr(5'h10, 32'd3);
    rd_chk("R6 hi commit", 5'h14, 32'd7);
    rd_chk("R6 lo commit", 5'h10, 32'd3);

    // R9/R10 one-shot at 110 from 100
    wr(5'h14, 32'd0);
    wr(5'h10, 32'd110);
    wr(5'h0C, 32'h1);
    wr(5'h08, 32'h1);
    exp_q.push_back(last_e + 10 + 2);
    rd(5'h00, v1);
    repeat (6) @(negedge clk);
    rd(5'h00, v2);
    chk("R2 rate", v2, v1 + 32'd7);
    repeat (30) @(negedge clk);
    wr(5'h08, 32'h0);
    rd_chk("R9 cmp kept", 5'h10, 32'd110);
    rd_chk("R9 ccfg", 5'h0C, 32'h11);

    // R7/R8 periodic: first match 30, period 10
    wr(5'h00, 32'd0);
    wr(5'h04, 32'd0);
    wr(5'h0C, 32'h7);
    wr(5'h14, 32'd0);
    rd_chk("R7 setval cleared by hi", 5'h0C, 32'h13);
    wr(5'h0C, 32'h7);
    wr(5'h10, 32'd30);
    rd_chk("R7 setval cleared", 5'h0C, 32'h13);
    rd_chk("R7 cmp loaded", 5'h10, 32'd30);
    wr(5'h14, 32'd0);
    wr(5'h10, 32'd10);
    rd_chk("R7 period write keeps cmp", 5'h10, 32'd30);
    wr(5'h08, 32'h1);
    exp_q.push_back(last_e + 32);
    exp_q.push_back(last_e + 42);
    exp_q.push_back(last_e + 52);
    repeat (52) @(negedge clk);
    wr(5'h00, 32'd0);
    wr(5'h08, 32'h0);
    rd_chk("R2 write ignored while on", 5'h00, 32'd54);
    rd_chk("R8 cmp advanced", 5'h10, 32'd60);

    // R5 narrow mode: wrap without carry, upper cmp ignored
    wr(5'h0C, 32'h9);
    wr(5'h04, 32'd1);
    wr(5'h00, 32'hFFFF_FFFE);
    wr(5'h14, 32'd5);
    wr(5'h10, 32'd1);
    rd_chk("R5 hi masked", 5'h04, 32'd0);
    wr(5'h08, 32'h1);
    exp_q.push_back(last_e + 5);
    repeat (3) @(negedge clk);
    wr(5'h08, 32'h0);
    wr(5'h0C, 32'h0);
    rd_chk("R5 no carry hi", 5'h04, 32'd0);
    rd_chk("R5 lo wrapped", 5'h00, 32'd2);
    rd_chk("R5 cmp hi kept", 5'h14, 32'd5);

    // R10 channel disabled: no irq
    wr(5'h00, 32'd0);
    wr(5'h14, 32'd0);
    wr(5'h10, 32'd5);
    wr(5'h08, 32'h1);
    repeat (10) @(negedge clk);
    wr(5'h08, 32'h0);
    repeat (5) @(negedge clk);

    while (exp_q.size() > 0) begin
      int x;
      x = exp_q.pop_front();
      vectors++;
      miscmp++;
      $display("FAIL R10 missing irq act=none exp=cycle %0d", x);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule